// File: doc/BRIEF.md
# Buffered-Update PWM Channel Group

A small group of pulse-width modulators. Each channel drives a complementary pair of outputs, a high side and a low side, with dead time inserted before each rising edge. Software never writes the live period, duty or dead-time of a running channel. It writes a shadow copy through a simple register write port. The shadow is copied into the live value at a well-defined moment, so a waveform never mixes old and new settings inside one period.

Each channel is either free-running or a member of a synchronous group that runs on channel 0's counter and period. Free-running channels take new values at the end of their own period. Synchronous channels follow a group-wide update method:

- **Method 0:** everything waits for a software unlock.
- **Methods 1 and 2:** period and dead time still wait for the unlock. Duty-cycle changes are paced by an update-period counter that counts whole group periods.

Top module: `pwm_group`

## Requirements
- R1: While reset is active both outputs of every channel are 0. After reset every channel has live period RST_PRD, duty 0 and dead time 0, no channel is synchronous, the method is 0 and the update period is 0. So the low side is 1 and the high side is 0.
- R2: A channel counter runs 0 to P-1 and restarts, where P is the live period. The high side is active while the count is below the duty D. With zero dead time the high side is 1 for D clocks and the low side for P-D clocks of each P-clock period, for any D from 1 to P-1.
- R3: Write addresses: channel c period shadow at 4c, duty shadow at 4c+1, dead-time shadow at 4c+2. At 4N are the mode bits: [N-1:0] is the synchronous mask and [N+1:N] is the update method. At 4N+1, bit 0 = 1 requests an unlock. At 4N+2, bits [UW-1:0] are the update period.
- R4: On a channel that is not synchronous, pending shadow values become live at the end of that channel's current period and are used from the next period on.
- R5: Synchronous channels use channel 0's counter and period. Under method 0 their pending period, duty and dead time stay pending until an unlock is requested, then become live at the next group period end.
- R6: The unlock request clears itself at the first group period end after it was set. Later shadow writes stay pending until a new unlock.
- R7: Under methods 1 and 2, pending period and dead time on synchronous channels still need an unlock and a group period end.
- R8: Under methods 1 and 2, a pending duty on a synchronous channel becomes live without an unlock, at a group period end where the update-period counter equals the update period. That counter advances once per group period and returns to 0 on that match. The update period itself is shadowed and becomes live on the same match.
- R9: When a shadow register is written several times before it is applied, only the last value becomes live.
- R10: Dead time T delays each rising edge of both sides by T clocks. The high side is 1 for D-T clocks and the low side for P-D-T clocks per period.
- R11: If T is at least the on-time or off-time of a side, that side stays 0 for the whole interval. The high and low sides of a channel are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | CW | Register write data |
| pwm_hi | output | NCH | High-side output per channel |
| pwm_lo | output | NCH | Low-side output per channel |

## Verification
A counter change reaches the high and low sides two clocks later, through the phase register and the output register.

A shadow written in a period becomes live at that period's end. So the bench writes just after it sees a rising edge on the high side. The period then being measured must still show the old values, and the period after it must show the new ones.

The monitor cuts the high-side stream into periods at each rising edge and compares each period's length and high and low counts with one queued item. Under an update-period count of 2, the new duty is due three group periods after the boundary that loads that count. Where dead time shifts the first new edge, the item for the one period that straddles the change is marked as not compared.

// File: rtl/pwm_group.sv
module pwm_group #(
  parameter int NCH = 2,
  parameter int CW = 8,
  parameter int UW = 4,
  parameter logic [CW-1:0] RST_PRD = CW'(10),
  localparam int GB = 4 * NCH,
  localparam int AW = $clog2(GB + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo
);

  logic [NCH-1:0]         sync_q;
  logic [1:0]             meth_q;
  logic                   unlock_q;
  logic [UW-1:0]          upr_q, upr_sh, upr_cnt;
  logic                   upr_pend;

  logic [NCH-1:0][CW-1:0] prd_q, dty_q, dt_q;
  logic [NCH-1:0][CW-1:0] prd_sh, dty_sh, dt_sh;
  logic [NCH-1:0][CW-1:0] cnt_q, dcnt_q;
  logic [NCH-1:0]         prd_pend, dty_pend, dt_pend;
  logic [NCH-1:0]         ph_q, hi_q, lo_q;

  logic [NCH-1:0]         wend, raw, ap_pd, ap_dy, w_prd, w_dty, w_dt;
  logic                   grp_end, lock_go, upr_hit, w_mode, w_unl, w_upr;

  assign grp_end = wend[0];
  assign lock_go = grp_end & unlock_q;
  assign upr_hit = grp_end & (upr_cnt == upr_q);
  assign w_mode  = wr_en & (wr_addr == AW'(GB));
  assign w_unl   = wr_en & (wr_addr == AW'(GB + 1)) & wr_data[0];
  assign w_upr   = wr_en & (wr_addr == AW'(GB + 2));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wend[c]  = ({1'b0, cnt_q[c]} + 1'b1) >= {1'b0, prd_q[c]};
    assign raw[c]   = (sync_q[c] ? cnt_q[0] : cnt_q[c]) < dty_q[c];
    assign ap_pd[c] = sync_q[c] ? lock_go : wend[c];
    assign ap_dy[c] = sync_q[c] ? ((meth_q == 2'd0) ? lock_go : upr_hit) : wend[c];
    assign w_prd[c] = wr_en & (wr_addr == AW'(4 * c));
    assign w_dty[c] = wr_en & (wr_addr == AW'(4 * c + 1));
    assign w_dt[c]  = wr_en & (wr_addr == AW'(4 * c + 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      meth_q   <= '0;
      unlock_q <= 1'b0;
      upr_q    <= '0;
      upr_sh   <= '0;
      upr_pend <= 1'b0;
      upr_cnt  <= '0;
      prd_q    <= {NCH{RST_PRD}};
      dty_q    <= '0;
      dt_q     <= '0;
      prd_sh   <= '0;
      dty_sh   <= '0;
      dt_sh    <= '0;
      prd_pend <= '0;
      dty_pend <= '0;
      dt_pend  <= '0;
      cnt_q    <= '0;
      dcnt_q   <= '0;
      ph_q     <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      if (w_mode) begin
        sync_q <= wr_data[NCH-1:0];
        meth_q <= wr_data[NCH+1:NCH];
      end

      if (w_unl)        unlock_q <= 1'b1;
      else if (grp_end) unlock_q <= 1'b0;

      if (w_upr) begin
        upr_sh   <= wr_data[UW-1:0];
        upr_pend <= 1'b1;
      end else if (upr_hit) begin
        upr_pend <= 1'b0;
      end
      if (upr_hit && upr_pend) upr_q <= upr_sh;

      if (upr_hit)      upr_cnt <= '0;
      else if (grp_end) upr_cnt <= upr_cnt + 1'b1;

      for (int c = 0; c < NCH; c++) begin
        cnt_q[c] <= (wend[c] || (sync_q[c] && grp_end)) ? '0 : cnt_q[c] + 1'b1;

        if (w_prd[c]) begin
          prd_sh[c]   <= wr_data;
          prd_pend[c] <= 1'b1;
        end else if (ap_pd[c]) begin
          prd_pend[c] <= 1'b0;
        end
        if (ap_pd[c] && prd_pend[c]) prd_q[c] <= prd_sh[c];

        if (w_dt[c]) begin
          dt_sh[c]   <= wr_data;
          dt_pend[c] <= 1'b1;
        end else if (ap_pd[c]) begin
          dt_pend[c] <= 1'b0;
        end
        if (ap_pd[c] && dt_pend[c]) dt_q[c] <= dt_sh[c];

        if (w_dty[c]) begin
          dty_sh[c]   <= wr_data;
          dty_pend[c] <= 1'b1;
        end else if (ap_dy[c]) begin
          dty_pend[c] <= 1'b0;
        end
        if (ap_dy[c] && dty_pend[c]) dty_q[c] <= dty_sh[c];

        ph_q[c]   <= raw[c];
        dcnt_q[c] <= (raw[c] != ph_q[c]) ? '0 :
                     (&dcnt_q[c])        ? dcnt_q[c] : dcnt_q[c] + 1'b1;
        hi_q[c]   <= ph_q[c]  && (dcnt_q[c] >= dt_q[c]);
        lo_q[c]   <= !ph_q[c] && (dcnt_q[c] >= dt_q[c]);
      end
    end
  end

  assign pwm_hi = hi_q;
  assign pwm_lo = lo_q;

endmodule

module pwm_group_chk #(
  parameter int NCH = 2,
  parameter int CW = 8,
  parameter int UW = 4,
  parameter int AW = 4,
  parameter int GB = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [NCH-1:0]         pwm_hi,
  input logic [NCH-1:0]         pwm_lo,
  input logic [NCH-1:0]         sync_q,
  input logic [NCH-1:0]         wend,
  input logic [1:0]             meth_q,
  input logic                   unlock_q,
  input logic                   grp_end,
  input logic [UW-1:0]          upr_cnt,
  input logic [UW-1:0]          upr_q,
  input logic [NCH-1:0][CW-1:0] prd_q,
  input logic [NCH-1:0][CW-1:0] dty_q,
  input logic [NCH-1:0][CW-1:0] cnt_q
);

  AST_UNLOCK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_q && grp_end && !(wr_en && wr_addr == AW'(GB + 1)) |=> !unlock_q); // R6

  AST_UPR_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    upr_cnt <= upr_q); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_SIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_hi[c] && pwm_lo[c])); // R11

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      prd_q[c] != '0 |-> cnt_q[c] < prd_q[c]); // R2

    AST_ASYNC_DUTY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sync_q[c]) && (dty_q[c] != $past(dty_q[c])) |-> $past(wend[c])); // R4

    AST_ASYNC_PRD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sync_q[c]) && (prd_q[c] != $past(prd_q[c])) |-> $past(wend[c])); // R4

    AST_SYNC_PRD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_q[c]) && (prd_q[c] != $past(prd_q[c])) |-> $past(unlock_q && grp_end)); // R7

    AST_M0_DUTY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_q[c]) && ($past(meth_q) == 2'd0) && (dty_q[c] != $past(dty_q[c]))
      |-> $past(unlock_q && grp_end)); // R5

    AST_M12_DUTY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_q[c]) && ($past(meth_q) != 2'd0) && (dty_q[c] != $past(dty_q[c]))
      |-> $past(grp_end && (upr_cnt == upr_q))); // R8
  end

endmodule

bind pwm_group pwm_group_chk #(.NCH(NCH), .CW(CW), .UW(UW), .AW(AW), .GB(GB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .sync_q(sync_q), .wend(wend),
  .meth_q(meth_q), .unlock_q(unlock_q), .grp_end(grp_end),
  .upr_cnt(upr_cnt), .upr_q(upr_q), .prd_q(prd_q), .dty_q(dty_q), .cnt_q(cnt_q)
);

// File: tb/test_pwm_group.sv
`timescale 1ns/1ps
module test_pwm_group;
  localparam int NCH = 2;
  localparam int CW  = 8;
  localparam int UW  = 4;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_hi, pwm_lo;

  pwm_group #(.NCH(NCH), .CW(CW), .UW(UW), .RST_PRD(8'd10)) i_pwm_group (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    len;
    int    hiw;
    int    low;
    string tag;
  } item_t;

  item_t q0[$];
  item_t q1[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic check(bit ok, string tag, string what, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic push(int c, int len, int hiw, int low, string tag);
    item_t it;
    it.len = len; it.hiw = hiw; it.low = low; it.tag = tag;
    if (c == 0) q0.push_back(it); else q1.push_back(it);
  endtask

  task automatic compare(int c, int len, int hiw, int low);
    item_t it;
    if (c == 0) begin
      if (q0.size() == 0) return;
      it = q0.pop_front();
    end else begin
      if (q1.size() == 0) return;
      it = q1.pop_front();
    end
    if (it.len == 0) return;
    n_chk++;
    if (len != it.len || hiw != it.hiw || low != it.low) begin
      n_bad++;
      $display("FAIL %s ch%0d period/high/low: got %0d/%0d/%0d expected %0d/%0d/%0d",
               it.tag, c, len, hiw, low, it.len, it.hiw, it.low);
    end
  endtask

  int m_len [NCH];
  int m_hi  [NCH];
  int m_lo  [NCH];
  bit m_on  [NCH];
  logic [NCH-1:0] m_prev = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (pwm_hi[c] && !m_prev[c]) begin
          if (m_on[c]) compare(c, m_len[c], m_hi[c], m_lo[c]);
          m_on[c] = 1'b1;
          m_len[c] = 0; m_hi[c] = 0; m_lo[c] = 0;
        end
        m_len[c]++;
        if (pwm_hi[c]) m_hi[c]++;
        if (pwm_lo[c]) m_lo[c]++;
        if (pwm_hi[c] && pwm_lo[c]) check(1'b0, "R11", "both sides high", 1, 0);
      end
      m_prev = pwm_hi;
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = CW'(d);
    @(posedge clk);
    #2;
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(int c);
    logic p;
    p = pwm_hi[c];
    forever begin
      @(negedge clk);
      if (pwm_hi[c] && !p) break;
      p = pwm_hi[c];
    end
    #2;
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    int hcnt, lcnt;
    repeat (3) @(negedge clk);
    check(pwm_hi == '0, "R1", "hi in reset", int'(pwm_hi), 0);
    check(pwm_lo == '0, "R1", "lo in reset", int'(pwm_lo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_hi == '0,  "R1", "hi after reset", int'(pwm_hi), 0);
    check(pwm_lo == '1,  "R1", "lo after reset", int'(pwm_lo), 3);
    #2;

    // R2 R3: basic waveforms through the channel address map
    wr(0, 10); wr(1, 3); wr(4, 12); wr(5, 4);
    repeat (40) @(negedge clk);
    wait_rise(0);
    repeat (3) push(0, 10, 3, 7, "R2 R3");
    drain();
    wait_rise(1);
    repeat (3) push(1, 12, 4, 8, "R2 R3");
    drain();

    // R4 R2: async update at period end, duty extremes
    wait_rise(0);
    wr(1, 1);
    push(0, 10, 3, 7, "R4 old duty kept");
    push(0, 10, 1, 9, "R2 duty 1");
    wait_rise(0);
    wr(1, 9);
    push(0, 10, 9, 1, "R2 duty P-1");
    wait_rise(0);
    // R9: two duty writes in one period, last one wins
    wr(1, 5); wr(1, 6); wr(0, 14);
    repeat (2) push(0, 14, 6, 8, "R9 R4");
    drain();

    // R10: dead time on channel 1
    wait_rise(1);
    wr(6, 2);
    push(1, 0, 0, 0, "R10");
    repeat (2) push(1, 12, 2, 6, "R10");
    drain();

    // R11: dead time longer than on-time
    wait_rise(1);
    wr(6, 5);
    repeat (40) @(negedge clk);
    hcnt = 0; lcnt = 0;
    repeat (48) begin
      @(negedge clk);
      if (pwm_hi[1]) hcnt++;
      if (pwm_lo[1]) lcnt++;
    end
    check(hcnt == 0,  "R11", "hi cycles", hcnt, 0);
    check(lcnt == 12, "R11", "lo cycles", lcnt, 12);
    #2;
    wr(6, 0);
    repeat (30) @(negedge clk);
    #2;

    // R5: synchronous group, method 0, held until unlock
    wr(8, 3);
    repeat (60) @(negedge clk);
    #2;
    wr(5, 7); wr(0, 16);
    repeat (60) @(negedge clk);
    wait_rise(1);
    repeat (2) push(1, 14, 4, 10, "R5 held");
    repeat (2) push(0, 14, 6, 8, "R5 held");
    drain();
    wait_rise(1);
    wr(9, 1);
    push(1, 14, 4, 10, "R5 unlock");
    push(1, 16, 7, 9, "R5 unlock");
    push(0, 14, 6, 8, "R5 unlock");
    push(0, 16, 6, 10, "R5 unlock");
    drain();

    // R6: unlock cleared after use
    wr(5, 2);
    wait_rise(1);
    repeat (3) push(1, 16, 7, 9, "R6 relocked");
    drain();

    // R8 R7: method 1 with update period 2
    wr(8, 7);
    repeat (60) @(negedge clk);
    wait_rise(1);
    wr(10, 2); wr(5, 5);
    push(1, 16, 2, 14, "R8");
    push(1, 16, 5, 11, "R8 upr match");
    wait_rise(1);
    wr(5, 9); wr(0, 20);
    repeat (2) push(1, 16, 5, 11, "R8 between matches");
    push(1, 16, 9, 7, "R8 third period");
    repeat (4) push(0, 16, 6, 10, "R7 period held");
    drain();
    wait_rise(1);
    wr(9, 1);
    push(0, 16, 6, 10, "R7 unlock");
    push(0, 20, 6, 14, "R7 unlock");
    drain();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule